// File: doc/BRIEF.md
# Boot ROM Adapter with No-Operation Fallback

This block is a read-only boot memory that answers instruction fetches from a processor core. It covers a 4 MiB byte address space and returns one 32-bit word per request. The read result and a valid strobe appear exactly one clock after the request. Reads can be issued on every cycle.

The block has two variants, and a parameter picks one at elaboration. With no preload image (`IMG_WORDS` = 0), no storage is built. Every address returns the all-zero no-operation word, so a core can run straight through a sled with no firmware present. With an image, a small table of words given as a parameter vector occupies the lowest word addresses. Every other address still returns the no-operation word. The block only stores and maps contents. It does not interpret boot configuration data or sequence the boot.

Top module: `boot_rom_adapter`

## Requirements
- R1: The read word is 32 bits. The word index is `addr_i[21:2]`, which spans 4 MiB of bytes. `addr_i[1:0]` has no effect on the returned data.
- R2: With `IMG_WORDS` = 0, every read returns 32'h0000_0000, the no-operation word.
- R3: A request with `req_i` high at clock edge N gives `rvalid_o` high after edge N+1, together with the word for that request's address.
- R4: `rvalid_o` is low in every cycle that does not follow an accepted request.
- R5: While no request is accepted, `rdata_o` holds the last word that was read.
- R6: `addr_i[31:22]` has no effect on the returned data, so addresses wrap within the 4 MiB window.
- R7: While `rst_n` is low, `rvalid_o` is driven to 0 and `rdata_o` is driven to 32'h0000_0000. The first read after reset returns the correct word.
- R8: With `IMG_WORDS` = K > 0, word index i < K returns `IMG_DATA[32*i +: 32]`. Every other word index returns 32'h0000_0000.
- R9: Requests on back-to-back cycles give valid data on back-to-back cycles, each word in request order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Read request strobe |
| addr_i | input | 32 | Byte address of the requested word |
| rdata_o | output | 32 | Read word, held between reads |
| rvalid_o | output | 1 | High for one cycle when `rdata_o` carries a new read |

## Verification
The in-RTL assertions check the timing rules on every cycle. Each request raises valid one cycle later, valid never rises without a request, data stays stable across idle cycles, reset clears valid, and the sled variant never returns anything but the no-operation word. Address mapping cannot be shown by properties: that the low and high address bits are ignored, that the wrap is correct, that the image words land at the right indices, and that reads are correct right after a mid-run reset. The bench's address sweeps show these by driving a sled instance and a small image instance side by side.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BYTE_OFFS = 2;
    localparam logic [WORD_W-1:0] NOP_WORD = '0;

    typedef logic [WORD_W-1:0] rom_word_t;

    typedef struct packed {
        logic      valid;
        rom_word_t data;
    } rd_state_t;

endpackage

// File: rtl/boot_rom_decode.sv
module boot_rom_decode #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ROM_BYTES = 4194304,
    localparam int unsigned ROM_AW   = $clog2(ROM_BYTES),
    localparam int unsigned IDX_W    = ROM_AW - boot_rom_pkg::BYTE_OFFS
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o
);

    // Low offset bits select a byte in the word; high bits lie outside the
    // window and are dropped so accesses wrap.
    logic [boot_rom_pkg::BYTE_OFFS-1:0] unused_offs;
    logic [ADDR_W-ROM_AW-1:0]           unused_high;

    always_comb begin
        idx_o       = addr_i[ROM_AW-1:boot_rom_pkg::BYTE_OFFS];
        unused_offs = addr_i[boot_rom_pkg::BYTE_OFFS-1:0];
        unused_high = addr_i[ADDR_W-1:ROM_AW];
    end

endmodule

// File: rtl/boot_rom_store.sv
module boot_rom_store #(
    parameter int unsigned IDX_W     = 20,
    parameter int unsigned IMG_WORDS = 0,
    parameter int unsigned IMG_CAP   = 1,
    parameter logic [32*IMG_CAP-1:0] IMG_DATA = '0
) (
    input  logic [IDX_W-1:0]       idx_i,
    output boot_rom_pkg::rom_word_t word_o
);

    generate
        if (IMG_WORDS == 0) begin : g_sled
            logic [IDX_W-1:0] unused_idx;
            always_comb begin
                unused_idx = idx_i;
                word_o     = boot_rom_pkg::NOP_WORD;
            end
        end else begin : g_image
            always_comb begin
                word_o = boot_rom_pkg::NOP_WORD;
                for (int k = 0; k < int'(IMG_WORDS); k++) begin
                    if (idx_i == IDX_W'(k)) begin
                        word_o = IMG_DATA[32*k +: 32];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/boot_rom_adapter.sv
module boot_rom_adapter #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ROM_BYTES = 4194304,
    parameter int unsigned IMG_WORDS = 0,
    parameter int unsigned IMG_CAP   = 1,
    parameter logic [32*IMG_CAP-1:0] IMG_DATA = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [31:0]       rdata_o,
    output logic              rvalid_o
);
    import boot_rom_pkg::*;

    localparam int unsigned ROM_AW = $clog2(ROM_BYTES);
    localparam int unsigned IDX_W  = ROM_AW - BYTE_OFFS;

    logic [IDX_W-1:0] word_idx;
    rom_word_t        lookup;
    rd_state_t        st_d, st_q;

    boot_rom_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_BYTES(ROM_BYTES)
    ) u_decode (
        .addr_i(addr_i),
        .idx_o (word_idx)
    );

    boot_rom_store #(
        .IDX_W    (IDX_W),
        .IMG_WORDS(IMG_WORDS),
        .IMG_CAP  (IMG_CAP),
        .IMG_DATA (IMG_DATA)
    ) u_store (
        .idx_i (word_idx),
        .word_o(lookup)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_i;
        if (req_i) begin
            st_d.data = lookup;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.data  <= NOP_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o  = st_q.data;
    assign rvalid_o = st_q.valid;

    // R3: each accepted request produces valid on the next cycle
    a_r3_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rvalid_o);

    // R4: valid only follows a request
    a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rvalid_o);

    // R5: data stays put across idle cycles
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(rdata_o));

    // R7: reset clears valid
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !rvalid_o);

    generate
        if (IMG_WORDS == 0) begin : g_sled_chk
            // R2: sled variant only ever returns the no-operation word
            a_r2_sled_only_nop: assert property (@(posedge clk) disable iff (!rst_n)
                rvalid_o |-> (rdata_o == NOP_WORD));
        end
    endgenerate

endmodule

// File: tb/boot_rom_adapter_bench.sv
module boot_rom_adapter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IMG_N      = 4;

    function automatic logic [31:0] pat(input int i);
        return 32'h1357_0000 + (i + 1) * 32'h0001_0203;
    endfunction

    function automatic logic [32*IMG_N-1:0] build_img();
        logic [32*IMG_N-1:0] v;
        for (int i = 0; i < IMG_N; i++) v[32*i +: 32] = pat(i);
        return v;
    endfunction

    localparam logic [32*IMG_N-1:0] IMG = build_img();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] rd_s, rd_i;
    logic        vl_s, vl_i;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_rom_adapter u_boot_rom_adapter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
        .rdata_o(rd_s), .rvalid_o(vl_s)
    );

    boot_rom_adapter #(
        .IMG_WORDS(IMG_N), .IMG_CAP(IMG_N), .IMG_DATA(IMG)
    ) u_boot_rom_adapter_img (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
        .rdata_o(rd_i), .rvalid_o(vl_i)
    );

    function automatic logic [31:0] exp_img(input logic [31:0] a);
        int idx;
        idx = int'(a[21:2]);
        return (idx < IMG_N) ? pat(idx) : 32'h0;
    endfunction

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    // Drive one request at a negedge; compare at the next negedge.
    task automatic read_chk(input logic [31:0] a, input string tag);
        @(negedge clk);
        req  = 1'b1;
        addr = a;
        @(negedge clk);
        req = 1'b0;
        chk({tag, " valid"}, {31'b0, vl_s & vl_i}, 32'd1);
        chk({tag, " sled"}, rd_s, 32'h0);
        chk({tag, " image"}, rd_i, exp_img(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 reset valid", {31'b0, vl_s | vl_i}, 32'd0);
        chk("R7 reset data", rd_i, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        // R7: first read after reset
        read_chk(32'h0000_0004, "R7 first read");

        // R1 R6 R2 R8: sweep of index, offset and high bits
        for (int i = 0; i < 2048; i++) begin
            logic [9:0]  hi;
            logic [19:0] idx;
            logic [1:0]  lo;
            hi  = 10'(i * 32'h9E37);
            idx = ((i % 16) < 8) ? 20'(i % 8) : 20'(i * 613);
            lo  = 2'(i);
            read_chk({hi, idx, lo}, "R1/R2/R6/R8 sweep");
        end

        // R6: wrap at top of window
        read_chk(32'hFFC0_0008, "R6 wrap");
        chk("R6 wrap word2", rd_i, pat(2));
        // R1: offset bits ignored
        read_chk(32'h0000_0007, "R1 offset");
        chk("R1 offset word1", rd_i, pat(1));
        // R8: first word past the image
        read_chk(32'h0000_0010, "R8 past image");

        // R9: back-to-back
        @(negedge clk);
        req = 1'b1; addr = 32'h0000_0000;
        @(negedge clk);
        chk("R9 b2b first", rd_i, pat(0));
        chk("R9 b2b first valid", {31'b0, vl_i}, 32'd1);
        addr = 32'h0000_000C;
        @(negedge clk);
        chk("R9 b2b second", rd_i, pat(3));
        chk("R9 b2b second valid", {31'b0, vl_i}, 32'd1);
        req = 1'b0;
        // R4 / R5: idle cycles hold data, no valid
        for (int k = 0; k < 4; k++) begin
            addr = 32'h0000_0004;
            @(negedge clk);
            chk("R4 idle valid", {31'b0, vl_s | vl_i}, 32'd0);
            chk("R5 hold data", rd_i, pat(3));
        end

        // R7: mid-run reset
        read_chk(32'h0000_0008, "R7 pre-reset");
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 midrun reset data", rd_i, 32'h0);
        chk("R7 midrun reset valid", {31'b0, vl_i}, 32'd0);
        rst_n = 1'b1;
        read_chk(32'h0040_0004, "R7 post-reset read");
        chk("R7 post-reset word1", rd_i, pat(1));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule